// File: doc/BRIEF.md
# A/D Start Trigger Qualifier

This block sits between a free-running sample strobe and the converter. It decides which strobes may pass as convert strobes. A one-cycle start command arms it in one of three policies, and a stop command returns it to idle.

- **Software start:** conversion begins straight away.
- **Edge start:** the block waits for the first qualifying edge of an external digital trigger. Once that edge has fired, the block keeps converting.
- **Level gating:** strobes pass only while the trigger sits at its active level. Conversion pauses when the trigger leaves that level and resumes when it returns.

The external trigger is asynchronous. It is brought into the clock domain by a flop chain before any edge or level decision is made. The mode, type and direction inputs are captured at the start command, so they may change freely while the block is running. A status output reports that the block is armed but held off by the trigger.

Top module: `adc_start_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `conv_stb` and `waiting` are 0.
- R2: With `src_ext`=0 at `arm`, the block runs from the next cycle. A `sample_stb` in the `arm` cycle is not passed. Every later strobe appears on `conv_stb` exactly one cycle after it.
- R3: With `src_ext`=1 and `kind_level`=0 at `arm`, no `conv_stb` occurs and `waiting`=1 until a qualifying edge is seen.
- R4: The edge direction is set by `dir_sel`: 00 selects a falling edge, 01 selects a rising edge, and 10 or 11 selects either edge. A qualifying edge seen on the synchronised trigger while waiting moves the block to run from the next cycle, and `waiting` drops.
- R5: Edges that appear on the synchronised trigger before `arm` do not start conversion.
- R6: After an edge start has fired, further trigger changes leave `conv_stb` following `sample_stb`.
- R7: In level mode (`src_ext`=1, `kind_level`=1), `dir_sel`=00 passes strobes only while the synchronised trigger is 0, and `dir_sel`=01 only while it is 1. In the held-off phase, `waiting`=1.
- R8: Level mode with `dir_sel`=10 or 11 behaves exactly as software start.
- R9: `trig_in` passes through a two-flop synchroniser (SYNC_STAGES=2). Edge and level decisions use the synchronised value, so they see the input two clocks late.
- R10: `disarm` returns the block to idle from any state, and it wins over a simultaneous `arm`. From the second cycle after `disarm`, `conv_stb` is 0. From the next cycle, `waiting` is 0.
- R11: Every `conv_stb` pulse is a whole copy of a `sample_stb` pulse from the previous cycle. It is never shortened or created by a trigger change.
- R12: The configuration inputs are latched at an accepted `arm`. Changing them afterwards, or pulsing `arm` again while not idle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start command pulse |
| disarm | input | 1 | Stop command pulse |
| src_ext | input | 1 | 0 = software start, 1 = external trigger |
| kind_level | input | 1 | 0 = edge start, 1 = level gating |
| dir_sel | input | 2 | 00 falling/low, 01 rising/high, 1x both |
| trig_in | input | 1 | Asynchronous external trigger |
| sample_stb | input | 1 | Free-running one-cycle sample strobe |
| conv_stb | output | 1 | Gated convert strobe |
| waiting | output | 1 | Armed and held off by the trigger |

## Verification
The bench goes after the following corner cases:
- **Strobe in the start cycle.** A design that leaked it would issue a convert before the start took effect.
- **Trigger edges made while idle.** A design that remembered them would fire at once on arming.
- **Trigger wiggles after an edge start.** A design with no fired latch would stop converting.
- **Level flips in both directions.** A design that gated combinationally would clip or invent strobes.
- **Stop and start in the same cycle.** A design that let start win would keep running.
- **Configuration changes while running.** A design without latched settings would switch policy mid-run.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_LEVEL = 2'd3
    } gate_st_e;

    typedef enum logic [1:0] {
        DIR_LOW  = 2'b00,
        DIR_HIGH = 2'b01,
        DIR_BOTH = 2'b10
    } dir_e;

    typedef struct packed {
        logic ext;
        logic level;
        dir_e dir;
    } trig_cfg_t;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } trig_view_t;

    function automatic dir_e dir_decode(input logic [1:0] code);
        case (code)
            2'b00:   return DIR_LOW;
            2'b01:   return DIR_HIGH;
            default: return DIR_BOTH;
        endcase
    endfunction

    function automatic logic edge_hit(input trig_cfg_t c, input trig_view_t v);
        case (c.dir)
            DIR_LOW:  return v.fall;
            DIR_HIGH: return v.rise;
            default:  return v.rise | v.fall;
        endcase
    endfunction

    function automatic logic level_hit(input trig_cfg_t c, input trig_view_t v);
        case (c.dir)
            DIR_LOW:  return ~v.lvl;
            DIR_HIGH: return v.lvl;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic starts_free(input trig_cfg_t c);
        return ~c.ext | (c.level & (c.dir == DIR_BOTH));
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl_in,
    output trig_view_t view
);
    logic prev_q;
    logic primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= lvl_in;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        view.lvl  = lvl_in;
        view.rise = primed_q &  lvl_in & ~prev_q;
        view.fall = primed_q & ~lvl_in &  prev_q;
    end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       disarm,
    input  trig_cfg_t  cfg_in,
    input  trig_view_t view,
    output logic       pass,
    output logic       hold
);
    gate_st_e  st_q;
    trig_cfg_t cfg_q;
    logic      lvl_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cfg_q <= '{ext: 1'b0, level: 1'b0, dir: DIR_LOW};
        end else if (disarm) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (arm) begin
                    cfg_q <= cfg_in;
                    if (starts_free(cfg_in))  st_q <= ST_RUN;
                    else if (cfg_in.level)    st_q <= ST_LEVEL;
                    else                      st_q <= ST_WAIT;
                end
                ST_WAIT: if (edge_hit(cfg_q, view)) st_q <= ST_RUN;
                default: st_q <= st_q;
            endcase
        end
    end

    always_comb begin
        lvl_ok = level_hit(cfg_q, view);
        pass   = (st_q == ST_RUN) | ((st_q == ST_LEVEL) & lvl_ok);
        hold   = (st_q == ST_WAIT) | ((st_q == ST_LEVEL) & ~lvl_ok);
    end
endmodule

// File: rtl/adc_trig_out.sv
module adc_trig_out (
    input  logic clk,
    input  logic rst,
    input  logic sample_stb,
    input  logic pass,
    output logic conv_stb
);
    always_ff @(posedge clk) begin
        if (rst) conv_stb <= 1'b0;
        else     conv_stb <= sample_stb & pass;
    end
endmodule

// File: rtl/adc_start_gate.sv
module adc_start_gate
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       disarm,
    input  logic       src_ext,
    input  logic       kind_level,
    input  logic [1:0] dir_sel,
    input  logic       trig_in,
    input  logic       sample_stb,
    output logic       conv_stb,
    output logic       waiting
);
    logic       trig_s;
    logic       pass;
    trig_view_t view;
    trig_cfg_t  cfg_in;

    always_comb begin
        cfg_in.ext   = src_ext;
        cfg_in.level = kind_level;
        cfg_in.dir   = dir_decode(dir_sel);
    end

    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(trig_in), .sync_out(trig_s)
    );

    adc_trig_edge u_edge (
        .clk(clk), .rst(rst), .lvl_in(trig_s), .view(view)
    );

    adc_trig_ctrl u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .disarm(disarm),
        .cfg_in(cfg_in), .view(view), .pass(pass), .hold(waiting)
    );

    adc_trig_out u_out (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .pass(pass),
        .conv_stb(conv_stb)
    );
endmodule

// File: rtl/adc_start_gate_chk.sv
module adc_start_gate_chk (
    input logic clk,
    input logic rst,
    input logic disarm,
    input logic sample_stb,
    input logic conv_stb,
    input logic waiting
);
    // R11
    whole_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        conv_stb |-> $past(sample_stb));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!conv_stb && !waiting));

    // R10
    stop_conv_chk: assert property (@(posedge clk) disable iff (rst)
        disarm |=> ##1 !conv_stb);

    // R10
    stop_wait_chk: assert property (@(posedge clk) disable iff (rst)
        disarm |=> !waiting);

    // R3
    held_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(waiting) |-> !conv_stb);
endmodule

bind adc_start_gate adc_start_gate_chk u_chk (
    .clk(clk), .rst(rst), .disarm(disarm), .sample_stb(sample_stb),
    .conv_stb(conv_stb), .waiting(waiting)
);

// File: tb/adc_start_gate_tb.sv
module adc_start_gate_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0, disarm = 1'b0;
    logic src_ext = 1'b0, kind_level = 1'b0;
    logic [1:0] dir_sel = 2'b00;
    logic trig_in = 1'b0;
    logic sample_stb = 1'b0;
    logic conv_stb, waiting;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_start_gate u_dut (
        .clk(clk), .rst(rst), .arm(arm), .disarm(disarm),
        .src_ext(src_ext), .kind_level(kind_level), .dir_sel(dir_sel),
        .trig_in(trig_in), .sample_stb(sample_stb),
        .conv_stb(conv_stb), .waiting(waiting)
    );

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    int stb_period = 3;
    int stb_cnt = 0;
    bit done = 0;

    // behavioural reference: 0 idle, 1 wait edge, 2 running, 3 level gated
    int  m_st = 0;
    bit  m_ext, m_lvl;
    bit [1:0] m_dir;
    bit  m_s1, m_s2, m_prev, m_primed;
    bit  e_conv, e_wait;

    function automatic bit lvl_act(bit [1:0] d, bit s);
        if (d[1]) return 1'b1;
        return d[0] ? s : ~s;
    endfunction

    always @(posedge clk) begin
        bit pass_now, edge_now;
        if (rst) begin
            m_st = 0; m_ext = 0; m_lvl = 0; m_dir = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_primed = 0; e_conv = 0;
        end else begin
            pass_now = (m_st == 2) || (m_st == 3 && lvl_act(m_dir, m_s2));
            if (!m_primed)      edge_now = 0;
            else if (m_dir[1])  edge_now = (m_s2 != m_prev);
            else if (m_dir[0])  edge_now = m_s2 && !m_prev;
            else                edge_now = !m_s2 && m_prev;
            e_conv = sample_stb && pass_now;
            if (disarm) m_st = 0;
            else if (m_st == 0 && arm) begin
                m_ext = src_ext; m_lvl = kind_level; m_dir = dir_sel;
                if (!src_ext || (kind_level && dir_sel[1])) m_st = 2;
                else if (kind_level) m_st = 3;
                else m_st = 1;
            end else if (m_st == 1 && edge_now) m_st = 2;
            m_primed = 1; m_prev = m_s2; m_s2 = m_s1; m_s1 = trig_in;
        end
        e_wait = (m_st == 1) || (m_st == 3 && !lvl_act(m_dir, m_s2));
    end

    task automatic cyc();
        @(negedge clk);
        checks++;
        if (conv_stb !== e_conv) begin
            fails++;
            $display("FAIL %s conv_stb actual=%b expected=%b at %0t", cur_req, conv_stb, e_conv, $time);
        end
        checks++;
        if (waiting !== e_wait) begin
            fails++;
            $display("FAIL %s waiting actual=%b expected=%b at %0t", cur_req, waiting, e_wait, $time);
        end
        stb_cnt++;
        sample_stb = (stb_cnt % stb_period) == 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_arm(bit ext, bit lvl, bit [1:0] d);
        src_ext = ext; kind_level = lvl; dir_sel = d; arm = 1; cyc(); arm = 0;
    endtask

    task automatic do_stop();
        disarm = 1; cyc(); disarm = 0; run(3);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(4); rst = 0; run(3);

        // R2: software start; align a strobe with the arm cycle
        cur_req = "R2";
        while (sample_stb != 1) cyc();
        do_arm(0, 0, 2'b00); run(12);
        cur_req = "R10"; do_stop();

        // R3 R4 R6 R9: falling edge start
        cur_req = "R3"; trig_in = 1; run(5);
        do_arm(1, 0, 2'b00); run(6);
        cur_req = "R4"; trig_in = 0; run(6);
        cur_req = "R6"; trig_in = 1; run(4); trig_in = 0; run(2); trig_in = 1; run(6);
        cur_req = "R10"; do_stop();

        // R5: edges while idle, then rising arm; R9 latency
        cur_req = "R5"; trig_in = 0; run(3); trig_in = 1; run(5);
        do_arm(1, 0, 2'b01); run(8);
        cur_req = "R9"; trig_in = 0; run(4); trig_in = 1; run(8);
        cur_req = "R10"; do_stop();

        // R4: either-edge start, with code 11
        cur_req = "R4"; stb_period = 2;
        do_arm(1, 0, 2'b11); run(5); trig_in = 0; run(8);
        do_stop();

        // R7: low-level gating
        cur_req = "R7"; stb_period = 1;
        trig_in = 1; run(4);
        do_arm(1, 1, 2'b00); run(5);
        for (int k = 0; k < 4; k++) begin trig_in = ~trig_in; run(3 + k); end
        do_stop();
        // R7: high-level gating
        do_arm(1, 1, 2'b01); run(4);
        for (int k = 0; k < 4; k++) begin trig_in = ~trig_in; run(2 + k); end
        do_stop();

        // R8: level both behaves like software start
        cur_req = "R8"; stb_period = 3;
        do_arm(1, 1, 2'b10); trig_in = 0; run(6); trig_in = 1; run(6);
        do_stop();

        // R12: config change and repeated arm while running have no effect
        cur_req = "R12";
        do_arm(0, 0, 2'b00); run(3);
        src_ext = 1; kind_level = 1; dir_sel = 2'b00; trig_in = 1; run(3);
        do_arm(1, 0, 2'b01); run(6);
        do_stop();

        // R10: disarm wins over simultaneous arm, from wait and idle
        cur_req = "R10";
        do_arm(1, 0, 2'b01); run(3);
        arm = 1; disarm = 1; cyc(); arm = 0; disarm = 0; run(6);

        // R11: whole strobes under fast level toggling
        cur_req = "R11"; stb_period = 2;
        do_arm(1, 1, 2'b01);
        for (int k = 0; k < 12; k++) begin trig_in = ~trig_in; cyc(); end
        run(4);
        do_stop();

        finish_up();
    end
endmodule